// File: doc/BRIEF.md
# Decode-Stage Branch Resolver with Delay-Slot Control

This unit sits in the decode stage of a 32-bit, five-stage in-order pipeline. Each cycle it receives the instruction word held in decode, that instruction's PC+4 value and the two source operands. The operands arrive already forwarded. For a conditional branch it compares the operands and forms the target address. It then steers the fetch unit's next-PC mux to the target or to PC+4, so a taken branch redirects fetch after exactly one following instruction. That following instruction is the architectural delay slot.

The delay slot is tracked by a three-state machine. `ST_RUN` is the normal state. `ST_SLOT_EXEC` means the instruction now in decode is a delay slot that must execute. `ST_SLOT_KILL` means the instruction now in decode is a delay slot that must become a no-op. The transitions are as follows:
- `ST_RUN` goes to `ST_SLOT_EXEC` after any ordinary branch, and after a likely branch that is taken.
- `ST_RUN` goes to `ST_SLOT_KILL` after a likely branch that falls through.
- Both slot states return to `ST_RUN` after one cycle.
- Without a branch, `ST_RUN` stays in `ST_RUN`.

While in `ST_SLOT_KILL` the unit raises the nullify output for that single cycle.

Top module: `branch_resolve_unit`

## Requirements
- R1: `br_target` always equals `id_pc4` plus the sign-extended `id_instr[15:0]` shifted left by two, modulo 2^32, in the same cycle.
- R2: The opcode is `id_instr[31:26]`. Opcodes 0x04 (equal) and 0x14 (equal, likely) are taken when `rs_data == rt_data`. Opcodes 0x05 (not equal) and 0x15 (not equal, likely) are taken when the operands differ.
- R3: `br_taken` and `next_pc` are combinational. `next_pc` equals `br_target` when `br_taken` is high, and equals `id_pc4` otherwise.
- R4: When `id_valid` is low, or the opcode is not one of the four branch opcodes, `br_taken` is low, `next_pc` equals `id_pc4`, and `slot_nullify` stays low in the next cycle.
- R5: A valid likely-form branch (0x14 or 0x15) that is not taken raises `slot_nullify` during the following cycle.
- R6: `slot_nullify` stays low after an ordinary branch, whether taken or not, and after a taken likely branch. When it does rise, it lasts exactly one cycle.
- R7: In the cycle right after a valid branch has been resolved, the instruction in decode is treated as a delay slot. Even if it carries a branch opcode, it is not taken, `next_pc` equals `id_pc4`, and no nullify follows.
- R8: After reset, `slot_nullify` is low and the unit is in `ST_RUN`, so the first valid branch is resolved normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_valid | input | 1 | Decode holds a real instruction |
| id_instr | input | 32 | Instruction word in decode |
| id_pc4 | input | 32 | Address of the instruction plus four |
| rs_data | input | 32 | First forwarded operand |
| rt_data | input | 32 | Second forwarded operand |
| br_taken | output | 1 | Branch resolved taken (next-PC select) |
| br_target | output | 32 | Computed branch target |
| next_pc | output | 32 | Address fetch uses next |
| slot_nullify | output | 1 | Delay-slot instruction now in decode becomes a no-op |

## Verification
`br_taken`, `br_target` and `next_pc` are due in the same cycle the inputs are presented. `slot_nullify` is due one clock edge later, for the single cycle in which the slot instruction sits in decode. The bench applies each input set at a falling edge. It checks the combinational results 2 ns later, before the next rising edge. It checks `slot_nullify` at the following falling edge, against a bench model that updates its slot state only at that rising edge.

// File: rtl/bru_pkg.sv
package bru_pkg;
    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_SLOT_EXEC = 2'd1,
        ST_SLOT_KILL = 2'd2
    } slot_state_t;
endpackage

// File: rtl/bru_decode.sv
module bru_decode #(
    parameter int OPW   = 6,
    parameter int XLEN  = 32,
    parameter logic [OPW-1:0] OP_EQ  = 6'h04,
    parameter logic [OPW-1:0] OP_NE  = 6'h05,
    parameter logic [OPW-1:0] OP_EQL = 6'h14,
    parameter logic [OPW-1:0] OP_NEL = 6'h15
) (
    input  logic            valid,
    input  logic            in_slot,
    input  logic [OPW-1:0]  opcode,
    input  logic [XLEN-1:0] a_val,
    input  logic [XLEN-1:0] b_val,
    output logic            resolve,
    output logic            likely,
    output logic            taken
);
    logic is_eq_kind;
    logic is_ne_kind;
    logic same;

    always_comb begin
        is_eq_kind = (opcode == OP_EQ) || (opcode == OP_EQL);
        is_ne_kind = (opcode == OP_NE) || (opcode == OP_NEL);
        same       = (a_val == b_val);
        resolve    = valid && !in_slot && (is_eq_kind || is_ne_kind);
        likely     = (opcode == OP_EQL) || (opcode == OP_NEL);
        taken      = resolve && (is_ne_kind ? !same : same);
    end
endmodule

// File: rtl/bru_target.sv
module bru_target #(
    parameter int XLEN = 32,
    parameter int IMMW = 16
) (
    input  logic [XLEN-1:0] pc4,
    input  logic [IMMW-1:0] offset,
    output logic [XLEN-1:0] target
);
    localparam int EXTW = XLEN - IMMW - 2;
    logic [XLEN-1:0] byte_off;

    always_comb begin
        byte_off = {{EXTW{offset[IMMW-1]}}, offset, 2'b00};
        target   = pc4 + byte_off;
    end
endmodule

// File: rtl/bru_slot_fsm.sv
module bru_slot_fsm
    import bru_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic resolve,
    input  logic likely,
    input  logic taken,
    output logic in_slot,
    output logic slot_nullify
);
    slot_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = ST_RUN;
        unique case (state)
            ST_RUN: begin
                if (resolve) begin
                    if (likely && !taken) state_nx = ST_SLOT_KILL;
                    else                  state_nx = ST_SLOT_EXEC;
                end
            end
            ST_SLOT_EXEC: state_nx = ST_RUN;
            ST_SLOT_KILL: state_nx = ST_RUN;
            default:      state_nx = ST_RUN;
        endcase
    end

    always_comb begin
        in_slot      = 1'b0;
        slot_nullify = 1'b0;
        unique case (state)
            ST_RUN:       ;
            ST_SLOT_EXEC: in_slot = 1'b1;
            ST_SLOT_KILL: begin
                in_slot      = 1'b1;
                slot_nullify = 1'b1;
            end
            default:      ;
        endcase
    end

    // R6
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_nullify |=> !slot_nullify);

    // R5
    nullify_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_nullify |-> $past(resolve && likely && !taken));

    // R6
    no_kill_after_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resolve && (!likely || taken)) |=> !slot_nullify);
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit #(
    parameter int XLEN = 32,
    parameter int OPW  = 6,
    parameter int IMMW = 16,
    parameter logic [OPW-1:0] OP_EQ  = 6'h04,
    parameter logic [OPW-1:0] OP_NE  = 6'h05,
    parameter logic [OPW-1:0] OP_EQL = 6'h14,
    parameter logic [OPW-1:0] OP_NEL = 6'h15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            id_valid,
    input  logic [XLEN-1:0] id_instr,
    input  logic [XLEN-1:0] id_pc4,
    input  logic [XLEN-1:0] rs_data,
    input  logic [XLEN-1:0] rt_data,
    output logic            br_taken,
    output logic [XLEN-1:0] br_target,
    output logic [XLEN-1:0] next_pc,
    output logic            slot_nullify
);
    localparam int OP_LSB = XLEN - OPW;

    logic [OPW-1:0] opcode;
    logic           resolve_w;
    logic           likely_w;
    logic           taken_w;
    logic           in_slot_w;
    logic           unused_fields;

    assign opcode        = id_instr[XLEN-1:OP_LSB];
    assign unused_fields = ^id_instr[OP_LSB-1:IMMW];

    bru_decode #(
        .OPW(OPW), .XLEN(XLEN),
        .OP_EQ(OP_EQ), .OP_NE(OP_NE), .OP_EQL(OP_EQL), .OP_NEL(OP_NEL)
    ) u_dec (
        .valid   (id_valid),
        .in_slot (in_slot_w),
        .opcode  (opcode),
        .a_val   (rs_data),
        .b_val   (rt_data),
        .resolve (resolve_w),
        .likely  (likely_w),
        .taken   (taken_w)
    );

    bru_target #(.XLEN(XLEN), .IMMW(IMMW)) u_tgt (
        .pc4    (id_pc4),
        .offset (id_instr[IMMW-1:0]),
        .target (br_target)
    );

    bru_slot_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .resolve      (resolve_w),
        .likely       (likely_w),
        .taken        (taken_w),
        .in_slot      (in_slot_w),
        .slot_nullify (slot_nullify)
    );

    always_comb begin
        br_taken = taken_w;
        next_pc  = taken_w ? br_target : id_pc4;
    end

    // R3
    redirect_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> (next_pc == br_target));

    // R2
    cond_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> ((rs_data == rt_data) == (opcode == OP_EQ || opcode == OP_EQL)));

    // R7
    slot_no_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resolve_w |=> !br_taken);

    // R4
    idle_no_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |-> (!br_taken && next_pc == id_pc4));
endmodule

// File: tb/sim_branch_resolve_unit.sv
`timescale 1ns/1ps
module sim_branch_resolve_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        id_valid = 1'b0;
    logic [31:0] id_instr = '0;
    logic [31:0] id_pc4 = '0;
    logic [31:0] rs_data = '0;
    logic [31:0] rt_data = '0;
    logic        br_taken;
    logic [31:0] br_target;
    logic [31:0] next_pc;
    logic        slot_nullify;

    int checks = 0;
    int errors = 0;
    bit m_slot = 1'b0;
    bit m_null = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    branch_resolve_unit u0 (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_instr(id_instr),
        .id_pc4(id_pc4), .rs_data(rs_data), .rt_data(rt_data),
        .br_taken(br_taken), .br_target(br_target), .next_pc(next_pc),
        .slot_nullify(slot_nullify)
    );

    function automatic logic [31:0] exp_target(input logic [31:0] pc4, input logic [15:0] off);
        return pc4 + {{14{off[15]}}, off, 2'b00};
    endfunction

    function automatic bit is_branch_op(input logic [5:0] op);
        return op == 6'h04 || op == 6'h05 || op == 6'h14 || op == 6'h15;
    endfunction

    function automatic bit exp_cond(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b);
        if (op == 6'h04 || op == 6'h14) return a == b;
        return a != b;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [31:0] ins, input logic [31:0] pc4,
                        input logic [31:0] a, input logic [31:0] b);
        logic [5:0] op;
        bit res;
        bit tk;
        @(negedge clk);
        // R5 R6: nullify reflects the previous cycle's decision
        chk(m_null ? "R5 nullify" : "R6 nullify", {31'd0, slot_nullify}, {31'd0, m_null});
        id_valid = v; id_instr = ins; id_pc4 = pc4; rs_data = a; rt_data = b;
        op  = ins[31:26];
        res = v && !m_slot && is_branch_op(op);
        tk  = res && exp_cond(op, a, b);
        #2;
        chk("R1 target", br_target, exp_target(pc4, ins[15:0]));
        if (m_slot && v && is_branch_op(op))
            chk("R7 slot taken", {31'd0, br_taken}, {31'd0, tk});
        else if (!res)
            chk("R4 taken", {31'd0, br_taken}, {31'd0, tk});
        else
            chk("R2 taken", {31'd0, br_taken}, {31'd0, tk});
        chk("R3 next_pc", next_pc, tk ? exp_target(pc4, ins[15:0]) : pc4);
        m_null = res && (op == 6'h14 || op == 6'h15) && !tk;
        m_slot = res;
    endtask

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [15:0] off);
        return {op, 5'd3, 5'd7, off};
    endfunction

    initial begin
        #1600000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        chk("R8 reset nullify", {31'd0, slot_nullify}, 32'd0);
        rst_n = 1'b1;
        // R8: first branch after reset resolves
        step(1, mk(6'h04, 16'hFFFC), 32'h0000_1000, 32'd5, 32'd5);
        step(1, mk(6'h00, 16'h0001), 32'h0000_0FF4, 32'd1, 32'd2);
        // R2 not-equal, not taken
        step(1, mk(6'h05, 16'h0010), 32'h0000_2000, 32'd9, 32'd9);
        step(1, mk(6'h00, 16'h0000), 32'h0000_2004, 32'd0, 32'd0);
        // R5 likely equal falls through
        step(1, mk(6'h14, 16'h0004), 32'h0000_3000, 32'd1, 32'd2);
        step(1, mk(6'h00, 16'h0000), 32'h0000_3004, 32'd0, 32'd0);
        step(0, 32'd0, 32'h0000_3008, 32'd0, 32'd0);
        // R6 likely not-equal taken: no nullify
        step(1, mk(6'h15, 16'h7FFF), 32'h0000_4000, 32'd1, 32'd2);
        step(1, mk(6'h00, 16'h0000), 32'h0002_4000, 32'd0, 32'd0);
        step(0, 32'd0, 32'h0000_0000, 32'd0, 32'd0);
        // R7 branch in delay slot ignored
        step(1, mk(6'h05, 16'h8000), 32'h0000_5000, 32'd1, 32'd2);
        step(1, mk(6'h04, 16'h0040), 32'h0000_5004, 32'd7, 32'd7);
        step(1, mk(6'h04, 16'h0040), 32'h0000_6004, 32'd7, 32'd7);
        step(0, 32'd0, 32'h0000_0000, 32'd0, 32'd0);
        // R1 wraparound, R4 invalid branch
        step(1, mk(6'h04, 16'h0008), 32'hFFFF_FFF8, 32'd3, 32'd3);
        step(0, mk(6'h04, 16'h0008), 32'h0000_0010, 32'd3, 32'd3);
        step(1, mk(6'h15, 16'h0001), 32'h0000_7000, 32'd3, 32'd3);
        step(1, mk(6'h15, 16'h0001), 32'h0000_7004, 32'd3, 32'd3);
        step(1, mk(6'h14, 16'h0001), 32'h0000_7008, 32'd3, 32'd4);
        step(1, mk(6'h00, 16'h0001), 32'h0000_700C, 32'd3, 32'd4);
        step(0, 32'd0, 32'd0, 32'd0, 32'd0);
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] op;
            logic [31:0] a;
            logic [31:0] b;
            case ($urandom % 8)
                0: op = 6'h04;
                1: op = 6'h05;
                2: op = 6'h14;
                3: op = 6'h15;
                default: op = 6'($urandom);
            endcase
            a = $urandom;
            b = ($urandom % 2) ? a : $urandom;
            step(($urandom % 8) != 0, {op, 10'($urandom), 16'($urandom)}, $urandom, a, b);
        end
        step(0, 32'd0, 32'd0, 32'd0, 32'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule